// File: doc/BRIEF.md
# Framed ASCII Stream Checksum Verifier

This block sits on the byte stream headed for a logic-device programmer. It waits for a start-of-text byte. From that byte on, it adds every character into a 16-bit running sum, up to and including the end-of-text byte. It then reads the four ASCII hex digits that follow and decodes them into the value the sender claims. It compares the two values and reports the result with a one-cycle done pulse and a held checksum-ok level. The block does not interpret the characters between the markers. It only checks that each one belongs to the permitted set and raises an error flag when one does not.

The byte input is a valid/ready interface. `in_ready` is always high, because the block takes one byte in every cycle in which `in_valid` is high and never pushes back. A byte is consumed exactly on a clock edge where `in_valid` is high. A cycle with `in_valid` low has no effect, whatever is on `in_data`. The status pins are plain registered levels and pulses.

Top module: `stx_sum_checker`

## Requirements
- R1: `in_ready` is high whenever reset is low. A byte is accepted only on a rising edge with `in_valid` high, and a cycle with `in_valid` low changes nothing.
- R2: While hunting, every accepted byte other than 0x02 is ignored: it is not summed and sets no flag. This holds for illegal bytes as well.
- R3: An accepted 0x02 while hunting opens a frame. The sum starts at 0x02, and every later byte up to and including the closing 0x03 is added modulo 2^16. This includes CR (0x0D) and LF (0x0A).
- R4: The four bytes accepted after the closing 0x03 form the expected sum, most significant digit first. Digits 0-9, A-F and a-f are all accepted.
- R5: `done` is high for exactly one cycle, the cycle after the fourth trailer byte is accepted. `sum_ok` is updated at that same edge and then holds its value until the next accepted 0x02.
- R6: `sum_ok` goes to 1 only when all four trailer bytes are hex digits and their value equals the running sum. Any non-hex trailer byte forces it to 0.
- R7: `frame_err` is set when a byte outside 0x20-0x7E and outside {0x02, 0x03, 0x0A, 0x0D} is accepted inside a frame or its trailer. An illegal byte inside the frame is still summed. The flag is cleared only by the next frame-opening 0x02 or by reset.
- R8: A 0x02 accepted while a frame is open sets `frame_err` and restarts the sum at 0x02. The frame stays open.
- R9: A synchronous reset returns the parser to hunting and clears the sum, `done`, `sum_ok` and `frame_err`.
- R10: After the fourth trailer byte, the parser hunts again, and bytes up to the next 0x02 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | `in_data` holds a byte this cycle |
| in_ready | output | 1 | Block accepts a byte this cycle (always high) |
| in_data | input | 8 | Stream byte |
| done | output | 1 | One-cycle pulse when a trailer has been read |
| sum_ok | output | 1 | Last trailer matched the sum; held until next frame |
| frame_err | output | 1 | Illegal character or nested start seen in this frame |

## Verification
The bench uses the default `SUM_W` of 16, so the trailer is four digits wide. It drives a frame of 600 tilde characters, whose sum passes 2^16, which makes the modulo wrap observable in the decoded compare. The default width also brings both digit cases, non-hex trailers, nested starts, mid-frame reset and stall cycles carrying 0x02 within reach of a few short frames.

// File: rtl/sscp_pkg.sv
package sscp_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_BODY, ST_TAIL} sscp_state_e;
  localparam logic [7:0] CH_STX = 8'h02;
  localparam logic [7:0] CH_ETX = 8'h03;
  localparam logic [7:0] CH_LF  = 8'h0A;
  localparam logic [7:0] CH_CR  = 8'h0D;
endpackage

// File: rtl/ssc_char_class.sv
module ssc_char_class
  import sscp_pkg::*;
(
  input  logic [7:0] ch,
  output logic       legal,
  output logic       hex_ok,
  output logic [3:0] nibble
);
  always_comb begin
    legal = ((ch >= 8'h20) && (ch <= 8'h7E)) ||
            (ch == CH_STX) || (ch == CH_ETX) || (ch == CH_LF) || (ch == CH_CR);
    hex_ok = 1'b1;
    nibble = 4'h0;
    if (ch >= 8'h30 && ch <= 8'h39)      nibble = 4'(ch - 8'h30);
    else if (ch >= 8'h41 && ch <= 8'h46) nibble = 4'(ch - 8'h37);
    else if (ch >= 8'h61 && ch <= 8'h66) nibble = 4'(ch - 8'h57);
    else                                 hex_ok = 1'b0;
  end
endmodule

// File: rtl/ssc_sum_accum.sv
module ssc_sum_accum #(
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             add,
  input  logic [7:0]       data,
  output logic [SUM_W-1:0] sum
);
  logic [SUM_W-1:0] ext;
  assign ext = {{(SUM_W-8){1'b0}}, data};

  always_ff @(posedge clk) begin
    if (rst)       sum <= '0;
    else if (load) sum <= ext;
    else if (add)  sum <= sum + ext;
  end

  a_r3_load_start: assert property (@(posedge clk) disable iff (rst)
    load |=> (sum == {{(SUM_W-8){1'b0}}, $past(data)}));
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!load && !add) |=> $stable(sum));
endmodule

// File: rtl/ssc_trailer_dec.sv
module ssc_trailer_dec #(
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             shift,
  input  logic [3:0]       nib,
  input  logic             nib_ok,
  input  logic [SUM_W-1:0] ref_sum,
  output logic             last,
  output logic             pass_next
);
  localparam int DIGITS = SUM_W / 4;
  localparam int CNT_W  = $clog2(DIGITS + 1);
  localparam int HELD_W = SUM_W - 4;

  logic [HELD_W-1:0] held;
  logic [CNT_W-1:0]  cnt;
  logic              bad;

  assign last      = (cnt == CNT_W'(DIGITS - 1));
  assign pass_next = !bad && nib_ok && ({held, nib} == ref_sum);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      held <= '0;
      cnt  <= '0;
      bad  <= 1'b0;
    end else if (shift) begin
      held <= {held[HELD_W-5:0], nib};
      bad  <= bad | !nib_ok;
      cnt  <= last ? '0 : cnt + 1'b1;
    end
  end

  a_r6_bad_sticky: assert property (@(posedge clk) disable iff (rst)
    (shift && !nib_ok && !last && !clr) |=> bad);
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(DIGITS));
endmodule

// File: rtl/stx_sum_checker.sv
module stx_sum_checker
  import sscp_pkg::*;
#(
  parameter int SUM_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       done,
  output logic       sum_ok,
  output logic       frame_err
);
  sscp_state_e      state_q;
  logic             done_q, ok_q, err_q;
  logic             legal, hex_ok, last, pass_next;
  logic [3:0]       nib;
  logic [SUM_W-1:0] sum_w;
  logic             is_stx, is_etx, open_stx, nest_stx, body_add, tail_acc, fin;

  assign in_ready = 1'b1;
  assign is_stx   = (in_data == CH_STX);
  assign is_etx   = (in_data == CH_ETX);
  assign open_stx = in_valid && (state_q == ST_HUNT) && is_stx;
  assign nest_stx = in_valid && (state_q == ST_BODY) && is_stx;
  assign body_add = in_valid && (state_q == ST_BODY) && !is_stx;
  assign tail_acc = in_valid && (state_q == ST_TAIL);
  assign fin      = tail_acc && last;

  ssc_char_class u_cls (.ch(in_data), .legal(legal), .hex_ok(hex_ok), .nibble(nib));

  ssc_sum_accum #(.SUM_W(SUM_W)) u_acc (
    .clk(clk), .rst(rst), .load(open_stx || nest_stx), .add(body_add),
    .data(in_data), .sum(sum_w));

  ssc_trailer_dec #(.SUM_W(SUM_W)) u_tail (
    .clk(clk), .rst(rst), .clr(body_add && is_etx), .shift(tail_acc),
    .nib(nib), .nib_ok(hex_ok), .ref_sum(sum_w), .last(last), .pass_next(pass_next));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= fin;
      if (open_stx) begin
        state_q <= ST_BODY;
        ok_q    <= 1'b0;
        err_q   <= 1'b0;
      end else if (nest_stx) begin
        err_q <= 1'b1;
      end else if (body_add) begin
        if (!legal) err_q <= 1'b1;
        if (is_etx) state_q <= ST_TAIL;
      end else if (tail_acc) begin
        if (!legal) err_q <= 1'b1;
        if (last) begin
          state_q <= ST_HUNT;
          ok_q    <= pass_next;
        end
      end
    end
  end

  assign done      = done_q;
  assign sum_ok    = ok_q;
  assign frame_err = err_q;

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r5_ok_holds: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && is_stx) && !fin) |=> $stable(sum_ok));
  a_r10_done_hunts: assert property (@(posedge clk) disable iff (rst)
    done |-> (state_q == ST_HUNT));
  a_r2_hunt_ignore: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HUNT && !(in_valid && is_stx)) |=>
      (state_q == ST_HUNT) && $stable(frame_err) && !done);
  a_r8_nested_restart: assert property (@(posedge clk) disable iff (rst)
    nest_stx |=> (sum_w == SUM_W'(2)) && frame_err && (state_q == ST_BODY));
  a_r1_ready_high: assert property (@(posedge clk) disable iff (rst) in_ready);
endmodule

// File: tb/stx_sum_checker_tb.sv
module stx_sum_checker_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, done, sum_ok, frame_err;

  int    n_chk = 0, n_fail = 0;
  bit    running = 1'b0, finished = 1'b0;
  string cur_req = "R9";

  // reference model state
  int       m_state = 0, m_cnt = 0;
  int       m_sum = 0, m_exp = 0;
  bit       m_bad = 0, m_done = 0, m_ok = 0, m_err = 0;
  logic [7:0] body_q[$];

  always #4 clk = ~clk;

  stx_sum_checker u_dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .done(done), .sum_ok(sum_ok), .frame_err(frame_err));

  function automatic bit legal_ch(input logic [7:0] c);
    return (c >= 8'h20 && c <= 8'h7E) || c == 8'h02 || c == 8'h03 || c == 8'h0A || c == 8'h0D;
  endfunction

  function automatic int hex_val(input logic [7:0] c);
    if (c >= "0" && c <= "9") return int'(c) - 48;
    if (c >= "A" && c <= "F") return int'(c) - 55;
    if (c >= "a" && c <= "f") return int'(c) - 87;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_sum = 0; m_done = 0; m_ok = 0; m_err = 0;
    end else begin
      m_done = 0;
      if (in_valid) begin
        if (m_state == 0) begin
          if (in_data == 8'h02) begin m_state = 1; m_sum = 2; m_ok = 0; m_err = 0; end
        end else if (m_state == 1) begin
          if (in_data == 8'h02) begin m_err = 1; m_sum = 2; end
          else begin
            m_sum = (m_sum + int'(in_data)) % 65536;
            if (!legal_ch(in_data)) m_err = 1;
            if (in_data == 8'h03) begin m_state = 2; m_cnt = 0; m_exp = 0; m_bad = 0; end
          end
        end else begin
          if (hex_val(in_data) < 0) m_bad = 1;
          else m_exp = m_exp * 16 + hex_val(in_data);
          if (hex_val(in_data) < 0) m_exp = m_exp * 16;
          if (!legal_ch(in_data)) m_err = 1;
          m_cnt++;
          if (m_cnt == 4) begin
            m_done = 1; m_ok = !m_bad && (m_exp == m_sum); m_state = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (running && !rst) begin
      n_chk++;
      if (done !== m_done || sum_ok !== m_ok || frame_err !== m_err) begin
        n_fail++;
        $display("FAIL %s cycle compare: actual done=%b ok=%b err=%b expected done=%b ok=%b err=%b",
                 cur_req, done, sum_ok, frame_err, m_done, m_ok, m_err);
      end
    end
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit gap);
    if (gap) begin
      @(negedge clk); in_valid = 1'b0; in_data = 8'h02;
    end
    @(negedge clk); in_valid = 1'b1; in_data = b;
  endtask

  task automatic push_str(input string s);
    for (int i = 0; i < s.len(); i++) body_q.push_back(s[i]);
  endtask

  function automatic int q_sum();
    int s = 5;
    foreach (body_q[i]) s += int'(body_q[i]);
    return s % 65536;
  endfunction

  // sends STX, body_q, ETX, trailer; checks the done pulse and flags
  task automatic run_frame(input string trl, input bit exp_ok, input bit exp_err,
                           input bit gap, input string req);
    send(8'h02, gap);
    foreach (body_q[i]) send(body_q[i], gap);
    send(8'h03, gap);
    for (int i = 0; i < 4; i++) send(trl[i], gap);
    @(negedge clk); in_valid = 1'b0;
    chk(done == 1'b1, {req, " done after 4th digit (R5)"}, int'(done), 1);
    chk(sum_ok == exp_ok, {req, " sum_ok"}, int'(sum_ok), int'(exp_ok));
    chk(frame_err == exp_err, {req, " frame_err"}, int'(frame_err), int'(exp_err));
    @(negedge clk);
    chk(done == 1'b0, "R5 done single cycle", int'(done), 0);
    body_q.delete();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    running = 1'b1;
    chk(done == 0 && sum_ok == 0 && frame_err == 0, "R9 reset state", int'({done, sum_ok, frame_err}), 0);
    chk(in_ready == 1'b1, "R1 ready high", int'(in_ready), 1);

    cur_req = "R2";
    send(8'h41, 0); send(8'h01, 0); send(8'hFF, 0); send(8'h03, 0); send("7", 0);
    @(negedge clk); in_valid = 1'b0;
    chk(frame_err == 0 && done == 0, "R2 pre-frame bytes ignored", int'(frame_err), 0);

    cur_req = "R3";
    push_str("QP20*"); body_q.push_back(8'h0D); body_q.push_back(8'h0A); push_str("L000 0101*");
    run_frame($sformatf("%04X", q_sum()), 1, 0, 0, "R3 R4 R6 upper-case match");

    cur_req = "R4";
    push_str("fuse map ok*"); body_q.push_back(8'h0D); body_q.push_back(8'h0A);
    run_frame($sformatf("%04x", q_sum()), 1, 0, 0, "R4 lower-case match");

    cur_req = "R6";
    push_str("ABC");
    run_frame($sformatf("%04X", (q_sum() + 1) % 65536), 0, 0, 0, "R6 mismatch");
    push_str("ABC");
    run_frame("01G2", 0, 0, 0, "R6 non-hex digit");

    cur_req = "R7";
    push_str("X"); body_q.push_back(8'h07); push_str("Y");
    run_frame($sformatf("%04X", q_sum()), 1, 1, 0, "R7 illegal char summed and flagged");

    cur_req = "R8";
    send(8'h02, 0); send("A", 0); send("B", 0);
    push_str("CD");
    run_frame($sformatf("%04X", q_sum()), 1, 1, 0, "R8 nested start restarts sum");

    cur_req = "R1";
    push_str("gap*test");
    run_frame($sformatf("%04X", q_sum()), 1, 0, 1, "R1 idle cycles ignored");

    cur_req = "R3";
    for (int i = 0; i < 600; i++) body_q.push_back(8'h7E);
    chk(q_sum() == 16'h2755, "R3 bench wrap value", q_sum(), 16'h2755);
    run_frame($sformatf("%04X", q_sum()), 1, 0, 0, "R3 modulo wrap");

    cur_req = "R10";
    send("Z", 0); send(8'h03, 0); send("0", 0); send("0", 0); send("0", 0); send("0", 0);
    send(8'h07, 0);
    @(negedge clk); in_valid = 1'b0;
    chk(done == 0 && sum_ok == 1 && frame_err == 0, "R10 hunting after done, R5 ok held",
        int'({done, sum_ok, frame_err}), 3'b010);
    send(8'h02, 0);
    @(negedge clk); in_valid = 1'b0;
    chk(sum_ok == 0, "R5 sum_ok cleared by next start", int'(sum_ok), 0);

    cur_req = "R9";
    send("A", 0); send(8'h07, 0);
    @(negedge clk); in_valid = 1'b0;
    chk(frame_err == 1, "R7 flag before reset", int'(frame_err), 1);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(frame_err == 0 && done == 0 && sum_ok == 0, "R9 mid-frame reset clears",
        int'({done, sum_ok, frame_err}), 0);
    send(8'h03, 0); send("1", 0); send("2", 0); send("3", 0); send("4", 0);
    @(negedge clk); in_valid = 1'b0;
    chk(done == 0, "R9 parser hunting after reset", int'(done), 0);
    push_str("after");
    run_frame($sformatf("%04X", q_sum()), 1, 0, 0, "R9 frame after reset");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule